// File: doc/BRIEF.md
# Clock-Synthesizer Bring-Up Sequencer

This block brings an external PLL clock-synthesizer chip out of reset and into a locked, synchronized state over SPI, without any processor. After the system reset is released it runs a fixed script. It holds the system clock selection on the standby source and pulses the chip's active-low reset. It then puts the serial port into unidirectional mode and reads back the chip identity. Next it streams one of two built-in register tables to the chip and commits them. It polls the lock-status bit, and finally runs an output-synchronization sequence in which every step is followed by a commit.

Once the synthesizer is synchronized, the sequencer moves the clock selection over to the synthesized source and pulses an active-low reset for the peripherals that run from those clocks. It then raises `done`. A wrong chip identity, or a lock that never arrives within a bounded number of polls, stops the script with `error` raised and `done` low.

Every transaction is a 24-bit frame handed to an external SPI shifter through a request/acknowledge pair. The frame stays on the port until the shifter acknowledges it, and the received 24-bit word is valid in the acknowledge cycle.

Top module: `clksynth_bringup`

## Requirements
- R1: Every frame has the read flag in bit 23 (1 = read, 0 = write), zeros in bits 22:20, the 12-bit register address in bits 19:8 and the write data in bits 7:0. A read frame carries 0x00 in bits 7:0. Read results are taken only from bits 7:0 of the received word.
- R2: During reset and for RST_CYCLES cycles after it, `chip_rst_n` is 0, `clk_sel` is 0, `periph_rst_n` is 1, `spi_req`, `done` and `error` are 0. `chip_rst_n` then returns to 1, and at least RST_CYCLES further cycles pass before the first request.
- R3: The first frame writes 0x99 to register 0x000. The second frame reads register 0x003.
- R4: If the identity read returns anything other than 0xC3 in bits 7:0, the sequencer raises `error`, keeps `done` and `clk_sel` at 0, and issues no further requests.
- R5: With `tbl_sel` = 0 the sequencer writes table A (TBL_A_LEN entries, entry i = address 0x010+2i, value 0x20+7i). With `tbl_sel` = 1 it writes table B (TBL_B_LEN entries, entry i = address 0x0A0+2i, value 0x40+3i). Entries go out in ascending i, followed by a commit write of 0x01 to register 0x232.
- R6: After the commit, register 0x01F is read repeatedly until a read returns bit 0 = 1. The other bits of the received byte have no effect.
- R7: If LOCK_POLLS consecutive lock reads all return bit 0 = 0, the sequencer raises `error`, keeps `done` and `clk_sel` at 0, and issues no further requests.
- R8: After lock, the sequencer writes 0x07 to 0x1E0, 0x01 to 0x232, 0x01 to 0x230, 0x01 to 0x232, 0x00 to 0x230 and 0x01 to 0x232, in that order.
- R9: After the last synchronization frame, `clk_sel` rises to 1 at least one cycle before `periph_rst_n` falls. `periph_rst_n` stays 0 for exactly PULSE_CYCLES cycles, then returns to 1 and `done` rises.
- R10: `spi_req` stays high with an unchanged `spi_frame` until a cycle in which `spi_ack` is high. It is low in the cycle after that. The script does not advance without an acknowledge.
- R11: `done` and `error` are never both high. Once either is raised it holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the script starts when it is released |
| tbl_sel | input | 1 | Base register table choice (0 = table A, 1 = table B), held stable during the run |
| spi_ack | input | 1 | One-cycle acknowledge from the SPI shifter: frame done |
| spi_rdata | input | 24 | Word received by the shifter, valid while `spi_ack` is high |
| spi_req | output | 1 | Frame request to the SPI shifter |
| spi_frame | output | 24 | Frame to shift out, stable while `spi_req` is high |
| chip_rst_n | output | 1 | Active-low reset to the synthesizer chip |
| clk_sel | output | 1 | System clock select (0 = standby source, 1 = synthesized source) |
| periph_rst_n | output | 1 | Active-low reset to peripherals clocked by the synthesizer |
| done | output | 1 | Bring-up finished successfully |
| error | output | 1 | Bring-up aborted (identity mismatch or lock timeout) |

## Verification
The script is run four times, against a bench model of the chip that answers reads and acknowledges each request after a latency that changes from frame to frame. In the first run table A is selected and lock arrives on the third poll; in the second, table B is selected and lock arrives on the first poll. Together these two runs show that the table choice, the number of polls and the variable handshake latency each shape the frame stream as they should. The unlocked poll answers carry 0xFE with non-zero upper bits, so a design that tests more than bit 0 of the low byte stands out. The other two runs are the abort paths: an identity of 0xC2 stops the script right after the second frame, and a lock bit that never sets ends it after exactly LOCK_POLLS reads. In both, no further frames, no clock switch and no `done` must follow.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;

  typedef enum logic [3:0] {
    ST_RST_LO,
    ST_RST_WAIT,
    ST_MODE,
    ST_ID,
    ST_TBL,
    ST_TBL_CMT,
    ST_LOCK,
    ST_SYNC,
    ST_CLKSW,
    ST_PRST,
    ST_DONE,
    ST_ERR
  } seq_state_t;

  typedef struct packed {
    logic [11:0] addr;
    logic [7:0]  val;
  } tbl_entry_t;

  localparam logic [11:0] A_PORTCFG = 12'h000;
  localparam logic [11:0] A_CHIPID  = 12'h003;
  localparam logic [11:0] A_LOCKST  = 12'h01F;
  localparam logic [11:0] A_VCODIV  = 12'h1E0;
  localparam logic [11:0] A_SYNCCTL = 12'h230;
  localparam logic [11:0] A_UPDATE  = 12'h232;

  localparam logic [7:0] V_PORTCFG = 8'h99;
  localparam logic [7:0] V_CHIPID  = 8'hC3;
  localparam logic [7:0] V_UPDATE  = 8'h01;
  localparam logic [7:0] V_VCOSTAT = 8'h07;

  localparam int unsigned SYNC_STEPS = 6;

  // 24-bit frame: read flag, three zero bits, address, data (zero on reads)
  function automatic logic [23:0] mk_frame(input logic rd, input logic [11:0] a,
                                           input logic [7:0] d);
    return {rd, 3'b000, a, (rd ? 8'h00 : d)};
  endfunction

  // Base table contents, computed per entry
  function automatic tbl_entry_t tbl_entry(input logic sel, input int unsigned idx);
    tbl_entry_t e;
    if (sel) begin
      e.addr = 12'h0A0 + 12'(2 * idx);
      e.val  = 8'h40 + 8'(3 * idx);
    end else begin
      e.addr = 12'h010 + 12'(2 * idx);
      e.val  = 8'h20 + 8'(7 * idx);
    end
    return e;
  endfunction

  // Output-synchronization script: odd steps are commits
  function automatic logic [23:0] sync_frame(input logic [2:0] step);
    case (step)
      3'd0:    return mk_frame(1'b0, A_VCODIV, V_VCOSTAT);
      3'd2:    return mk_frame(1'b0, A_SYNCCTL, 8'h01);
      3'd4:    return mk_frame(1'b0, A_SYNCCTL, 8'h00);
      default: return mk_frame(1'b0, A_UPDATE, V_UPDATE);
    endcase
  endfunction

endpackage

// File: rtl/cs_table_rom.sv
module cs_table_rom
  import clksynth_pkg::*;
#(
  parameter int LEN_A = 5,
  parameter int LEN_B = 3,
  parameter int IDX_W = 3
) (
  input  logic             sel,
  input  logic [IDX_W-1:0] idx,
  output tbl_entry_t       entry,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_A = IDX_W'(LEN_A - 1);
  localparam logic [IDX_W-1:0] LAST_B = IDX_W'(LEN_B - 1);

  tbl_entry_t rom_a [LEN_A];
  tbl_entry_t rom_b [LEN_B];

  for (genvar g = 0; g < LEN_A; g++) begin : g_rom_a
    assign rom_a[g] = tbl_entry(1'b0, g);
  end
  for (genvar g = 0; g < LEN_B; g++) begin : g_rom_b
    assign rom_b[g] = tbl_entry(1'b1, g);
  end

  tbl_entry_t ent_a, ent_b;

  always_comb begin
    ent_a = rom_a[0];
    for (int i = 0; i < LEN_A; i++)
      if (idx == IDX_W'(i)) ent_a = rom_a[i];
  end

  always_comb begin
    ent_b = rom_b[0];
    for (int i = 0; i < LEN_B; i++)
      if (idx == IDX_W'(i)) ent_b = rom_b[i];
  end

  assign entry = sel ? ent_b : ent_a;
  assign last  = sel ? (idx == LAST_B) : (idx == LAST_A);

endmodule

// File: rtl/cs_cycle_timer.sv
module cs_cycle_timer #(
  parameter int W    = 10,
  parameter int INIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= W'(INIT);
    else if (load)
      cnt <= ld_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/cs_spi_port.sv
module cs_spi_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [23:0] frame_in,
  input  logic        spi_ack,
  input  logic [23:0] spi_rdata,
  output logic        spi_req,
  output logic [23:0] spi_frame,
  output logic        fin,
  output logic [7:0]  rbyte
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spi_req   <= 1'b0;
      spi_frame <= '0;
    end else if (spi_req && spi_ack) begin
      spi_req <= 1'b0;
    end else if (issue && !spi_req) begin
      spi_req   <= 1'b1;
      spi_frame <= frame_in;
    end
  end

  assign fin   = spi_req && spi_ack;
  assign rbyte = spi_rdata[7:0];

  logic unused_rx_hi;
  assign unused_rx_hi = ^spi_rdata[23:8];

endmodule

// File: rtl/clksynth_bringup.sv
module clksynth_bringup
  import clksynth_pkg::*;
#(
  parameter int RST_CYCLES   = 1000,
  parameter int PULSE_CYCLES = 16,
  parameter int LOCK_POLLS   = 4096,
  parameter int TBL_A_LEN    = 5,
  parameter int TBL_B_LEN    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tbl_sel,
  input  logic        spi_ack,
  input  logic [23:0] spi_rdata,
  output logic        spi_req,
  output logic [23:0] spi_frame,
  output logic        chip_rst_n,
  output logic        clk_sel,
  output logic        periph_rst_n,
  output logic        done,
  output logic        error
);

  localparam int MAX_LEN   = (TBL_A_LEN > TBL_B_LEN) ? TBL_A_LEN : TBL_B_LEN;
  localparam int IDX_W     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int MAX_DLY   = (RST_CYCLES > PULSE_CYCLES) ? RST_CYCLES : PULSE_CYCLES;
  localparam int TMR_W     = $clog2(MAX_DLY + 1);
  localparam int POLL_W    = $clog2(LOCK_POLLS + 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(LOCK_POLLS - 1);
  localparam logic [TMR_W-1:0]  RST_LD    = TMR_W'(RST_CYCLES - 1);
  localparam logic [TMR_W-1:0]  PULSE_LD  = TMR_W'(PULSE_CYCLES - 1);
  localparam logic [2:0]        SYNC_LAST = 3'(SYNC_STEPS - 1);

  seq_state_t        st;
  logic              launched;
  logic [IDX_W-1:0]  idx;
  logic [POLL_W-1:0] poll_cnt;
  logic [2:0]        step;

  // Named internal events, also observed by the checker
  logic        issue, fin;
  logic [7:0]  rbyte;
  logic        id_bad, lock_seen, poll_expired;
  logic        tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic [23:0] next_frame;
  logic        needs_spi;
  tbl_entry_t  rom_ent;
  logic        rom_last;

  cs_table_rom #(
    .LEN_A (TBL_A_LEN),
    .LEN_B (TBL_B_LEN),
    .IDX_W (IDX_W)
  ) u_rom (
    .sel   (tbl_sel),
    .idx   (idx),
    .entry (rom_ent),
    .last  (rom_last)
  );

  cs_cycle_timer #(
    .W    (TMR_W),
    .INIT (RST_CYCLES - 1)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .ld_val (tmr_val),
    .zero   (tmr_zero)
  );

  cs_spi_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .frame_in  (next_frame),
    .spi_ack   (spi_ack),
    .spi_rdata (spi_rdata),
    .spi_req   (spi_req),
    .spi_frame (spi_frame),
    .fin       (fin),
    .rbyte     (rbyte)
  );

  // Frame for the current script step
  always_comb begin
    needs_spi  = 1'b1;
    next_frame = '0;
    case (st)
      ST_MODE:    next_frame = mk_frame(1'b0, A_PORTCFG, V_PORTCFG);
      ST_ID:      next_frame = mk_frame(1'b1, A_CHIPID, 8'h00);
      ST_TBL:     next_frame = mk_frame(1'b0, rom_ent.addr, rom_ent.val);
      ST_TBL_CMT: next_frame = mk_frame(1'b0, A_UPDATE, V_UPDATE);
      ST_LOCK:    next_frame = mk_frame(1'b1, A_LOCKST, 8'h00);
      ST_SYNC:    next_frame = sync_frame(step);
      default:    needs_spi  = 1'b0;
    endcase
  end

  assign issue        = needs_spi && !launched;
  assign id_bad       = fin && (st == ST_ID) && (rbyte != V_CHIPID);
  assign lock_seen    = fin && (st == ST_LOCK) && rbyte[0];
  assign poll_expired = fin && (st == ST_LOCK) && !rbyte[0] && (poll_cnt == POLL_LAST);

  assign tmr_load = ((st == ST_RST_LO) && tmr_zero) || (st == ST_CLKSW);
  assign tmr_val  = (st == ST_CLKSW) ? PULSE_LD : RST_LD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RST_LO;
      launched <= 1'b0;
      idx      <= '0;
      poll_cnt <= '0;
      step     <= '0;
    end else begin
      if (issue)    launched <= 1'b1;
      else if (fin) launched <= 1'b0;
      case (st)
        ST_RST_LO:   if (tmr_zero) st <= ST_RST_WAIT;
        ST_RST_WAIT: if (tmr_zero) st <= ST_MODE;
        ST_MODE:     if (fin) st <= ST_ID;
        ST_ID:       if (fin) st <= id_bad ? ST_ERR : ST_TBL;
        ST_TBL: begin
          if (fin) begin
            if (rom_last) begin
              idx <= '0;
              st  <= ST_TBL_CMT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_TBL_CMT: begin
          if (fin) begin
            poll_cnt <= '0;
            st       <= ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (lock_seen) begin
            step <= '0;
            st   <= ST_SYNC;
          end else if (poll_expired) begin
            st <= ST_ERR;
          end else if (fin) begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_SYNC: begin
          if (fin) begin
            if (step == SYNC_LAST) st <= ST_CLKSW;
            else                   step <= step + 1'b1;
          end
        end
        ST_CLKSW: st <= ST_PRST;
        ST_PRST:  if (tmr_zero) st <= ST_DONE;
        default:  st <= st;
      endcase
    end
  end

  assign chip_rst_n   = (st != ST_RST_LO);
  assign clk_sel      = (st == ST_CLKSW) || (st == ST_PRST) || (st == ST_DONE);
  assign periph_rst_n = (st != ST_PRST);
  assign done         = (st == ST_DONE);
  assign error        = (st == ST_ERR);

endmodule

// File: rtl/cs_bringup_chk.sv
module cs_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_req,
  input logic        spi_ack,
  input logic [23:0] spi_frame,
  input logic        chip_rst_n,
  input logic        clk_sel,
  input logic        periph_rst_n,
  input logic        done,
  input logic        error,
  input logic        id_bad,
  input logic        lock_seen,
  input logic        poll_expired
);

  // R1
  frame_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> (spi_frame[22:20] == 3'b000) && (!spi_frame[23] || spi_frame[7:0] == 8'h00));

  // R2
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_rst_n |-> !spi_req && !clk_sel);

  // R4
  id_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_bad |=> error && !done);

  // R7
  lock_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expired |=> error && !done);

  // R6
  lock_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_seen |=> !error);

  // R4
  error_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !spi_req && !clk_sel);

  // R9
  clk_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_rst_n |-> clk_sel);

  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && !spi_ack |=> spi_req && $stable(spi_frame));

  // R10
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req && spi_ack |=> !spi_req);

  // R11
  exclusive_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R11
  error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

endmodule

bind clksynth_bringup cs_bringup_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spi_req      (spi_req),
  .spi_ack      (spi_ack),
  .spi_frame    (spi_frame),
  .chip_rst_n   (chip_rst_n),
  .clk_sel      (clk_sel),
  .periph_rst_n (periph_rst_n),
  .done         (done),
  .error        (error),
  .id_bad       (id_bad),
  .lock_seen    (lock_seen),
  .poll_expired (poll_expired)
);

// File: tb/sim_clksynth_bringup.sv
`timescale 1ns/100ps
module sim_clksynth_bringup;

  localparam int RSTC  = 4;
  localparam int PULSE = 3;
  localparam int LP    = 5;
  localparam int LEN_A = 5;
  localparam int LEN_B = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_sel = 1'b0;
  logic        spi_ack = 1'b0;
  logic [23:0] spi_rdata = '0;
  logic        spi_req;
  logic [23:0] spi_frame;
  logic        chip_rst_n, clk_sel, periph_rst_n, done, error;

  always #2.5 clk = ~clk;

  clksynth_bringup #(
    .RST_CYCLES   (RSTC),
    .PULSE_CYCLES (PULSE),
    .LOCK_POLLS   (LP),
    .TBL_A_LEN    (LEN_A),
    .TBL_B_LEN    (LEN_B)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .tbl_sel (tbl_sel),
    .spi_ack (spi_ack), .spi_rdata (spi_rdata),
    .spi_req (spi_req), .spi_frame (spi_frame),
    .chip_rst_n (chip_rst_n), .clk_sel (clk_sel), .periph_rst_n (periph_rst_n),
    .done (done), .error (error)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [23:0] exp_q[$];
  string       tag_q[$];
  string       extra_tag = "R10";

  task automatic push_wr(input logic [11:0] a, input logic [7:0] d, input string tag);
    exp_q.push_back({1'b0, 3'b000, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic push_rd(input logic [11:0] a, input string tag);
    exp_q.push_back({1'b1, 3'b000, a, 8'h00});
    tag_q.push_back(tag);
  endtask

  // Chip model parameters for the current run
  logic [7:0] id_val = 8'hC3;
  int lock_after = 1;
  int poll_seen = 0;
  int nfr = 0;

  // Chip model and monitor: acknowledges with varying latency, compares frames
  initial begin : slave
    int wait_cnt;
    int lat;
    logic [23:0] first_fr;
    wait_cnt = 0;
    lat = 0;
    first_fr = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        spi_ack = 1'b0;
        wait_cnt = 0;
        lat = 0;
      end else if (spi_ack) begin
        spi_ack = 1'b0;
      end else if (spi_req) begin
        if (wait_cnt == 0) first_fr = spi_frame;
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          chk(spi_frame == first_fr, "R10", "frame held until ack", spi_frame, first_fr);
          if (exp_q.size() == 0) begin
            chk(1'b0, extra_tag, "unexpected frame", spi_frame, 0);
          end else begin
            logic [23:0] ef;
            string t;
            ef = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(spi_frame == ef, t, "frame", spi_frame, ef);
          end
          if (spi_frame[23] && spi_frame[19:8] == 12'h003)
            spi_rdata = {16'h5AA5, id_val};
          else if (spi_frame[23] && spi_frame[19:8] == 12'h01F) begin
            poll_seen++;
            if (lock_after != 0 && poll_seen >= lock_after) spi_rdata = {16'h3C00, 8'h01};
            else spi_rdata = {16'h00FF, 8'hFE};
          end else
            spi_rdata = 24'hFFFFFF;
          spi_ack = 1'b1;
          wait_cnt = 0;
          nfr++;
          lat = nfr % 3;
        end
      end
    end
  end

  // One bring-up run; lock_n = 0 means the lock bit never sets
  task automatic run(input logic sel, input logic [7:0] idv, input int lock_n,
                     input bit exp_done, input string end_tag);
    int lo, hi, prst_lo, cyc, post_req;
    bit cs_seen_before;
    @(negedge clk);
    rst_n = 1'b0;
    tbl_sel = sel;
    id_val = idv;
    lock_after = lock_n;
    poll_seen = 0;
    exp_q.delete();
    tag_q.delete();
    extra_tag = end_tag;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(!chip_rst_n && !clk_sel && periph_rst_n && !spi_req && !done && !error, "R2",
        "reset state", {chip_rst_n, clk_sel, periph_rst_n, spi_req, done, error}, 6'b001000);
    // Expected frame stream
    push_wr(12'h000, 8'h99, "R3");
    push_rd(12'h003, "R3");
    if (idv == 8'hC3) begin
      for (int i = 0; i < (sel ? LEN_B : LEN_A); i++) begin
        if (sel) push_wr(12'h0A0 + 12'(2 * i), 8'h40 + 8'(3 * i), "R5");
        else     push_wr(12'h010 + 12'(2 * i), 8'h20 + 8'(7 * i), "R5");
      end
      push_wr(12'h232, 8'h01, "R5");
      for (int i = 0; i < ((lock_n == 0) ? LP : lock_n); i++)
        push_rd(12'h01F, (lock_n == 0) ? "R7" : "R6");
      if (lock_n != 0) begin
        push_wr(12'h1E0, 8'h07, "R8");
        push_wr(12'h232, 8'h01, "R8");
        push_wr(12'h230, 8'h01, "R8");
        push_wr(12'h232, 8'h01, "R8");
        push_wr(12'h230, 8'h00, "R8");
        push_wr(12'h232, 8'h01, "R8");
      end
    end
    rst_n = 1'b1;
    lo = 0;
    while (!chip_rst_n && lo < 1000) begin
      lo++;
      @(negedge clk);
    end
    chk(lo == RSTC, "R2", "chip reset low cycles", lo, RSTC);
    hi = 0;
    while (!spi_req && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
    chk(hi >= RSTC, "R2", "release-to-request cycles", hi, RSTC);
    prst_lo = 0;
    cs_seen_before = 1'b0;
    cyc = 0;
    while (!done && !error && cyc < 3000) begin
      if (!periph_rst_n) prst_lo++;
      if (clk_sel && periph_rst_n && prst_lo == 0) cs_seen_before = 1'b1;
      cyc++;
      @(negedge clk);
    end
    post_req = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (spi_req) post_req++;
      if (done != exp_done || error != !exp_done)
        chk(1'b0, "R11", "end flags held", {done, error}, {exp_done, !exp_done});
    end
    chk(exp_q.size() == 0, end_tag, "frames still expected", exp_q.size(), 0);
    chk(done == exp_done, end_tag, "done", done, exp_done);
    chk(error == !exp_done, end_tag, "error", error, !exp_done);
    chk(!(done && error), "R11", "done and error exclusive", {done, error}, 2'b10);
    chk(clk_sel == exp_done, end_tag, "clk_sel at end", clk_sel, exp_done);
    chk(periph_rst_n == 1'b1, "R9", "peripheral reset released", periph_rst_n, 1);
    chk(prst_lo == (exp_done ? PULSE : 0), "R9", "peripheral reset low cycles",
        prst_lo, exp_done ? PULSE : 0);
    if (exp_done) chk(cs_seen_before, "R9", "clk_sel before peripheral reset",
                      cs_seen_before, 1);
    chk(post_req == 0, end_tag, "requests after end", post_req, 0);
  endtask

  initial begin : main
    run(1'b0, 8'hC3, 3, 1'b1, "R9");   // table A, lock on third poll (R5, R6)
    run(1'b1, 8'hC3, 1, 1'b1, "R9");   // table B, lock on first poll (R5)
    run(1'b0, 8'hC2, 1, 1'b0, "R4");   // identity mismatch
    run(1'b1, 8'hC3, 0, 1'b0, "R7");   // lock never arrives
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule